// File: doc/BRIEF.md
# Serial Bus Hold-Pause Gate

This block sits between the pins of a serial memory slave (active-low select, serial clock, serial data in, serial data out and an active-low pause request) and the slave's internal shift logic. A fast system clock oversamples the pins. The block turns the serial clock into single-cycle rising and falling strobes, and it presents a registered copy of the data-in bit for the shift logic to use.

The host can stop a transfer partway through by driving the pause request low. The block then freezes the strobes and the data-in copy and turns the output driver off. While it is paused, the internal bit position does not move. After release, shifting picks up at the same bit.

The serial clock level qualifies both entry to and exit from the pause. A request made while the clock is high waits for the next falling edge. Release needs a rising edge of the request while the clock is low. Raising select ends the transaction and always clears a pause.

Top module: `serial_hold_gate`

## Requirements
- R1: With select active and the pause not already in effect, a low pause request seen while the serial clock is low puts the block into the paused state. The `paused` output goes high three system clocks after the pins change (two synchronizer stages plus the state register).
- R2: A low pause request seen while the serial clock is high takes effect only at the next falling edge of the serial clock. That falling edge is still forwarded as one `sck_fall` strobe.
- R3: The pause is left only when the pause request rises while the serial clock is low. If the request rises while the clock is high, the block stays paused, even after the clock later falls.
- R4: While paused, `sck_rise` and `sck_fall` stay low and `sdi_bit` holds its value, whatever the serial clock and data-in pins do.
- R5: `ser_oe` is high only when select is active, the pause request is high, the block is not paused and `core_oe` is high. In every other case it is low. `ser_dout` follows `core_dout`.
- R6: A pause does not reset the sequence. A byte shifted MSB first with a pause in the middle arrives whole, with one `sck_rise` per serial clock pulse outside the pause.
- R7: Select going high (inactive) clears the paused state. No strobes are produced while select is inactive.
- R8: Each serial clock edge seen while the block is running and selected gives exactly one strobe, one system clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Select pin, active low |
| ser_clk | input | 1 | Serial clock pin |
| ser_din | input | 1 | Serial data-in pin |
| pause_req_n | input | 1 | Pause request pin, active low |
| core_dout | input | 1 | Data-out bit from the internal shift logic |
| core_oe | input | 1 | Output enable request from the internal shift logic |
| sel_active | output | 1 | Synchronized select, active high |
| sck_rise | output | 1 | One-cycle strobe on a forwarded rising serial clock edge |
| sck_fall | output | 1 | One-cycle strobe on a forwarded falling serial clock edge |
| sdi_bit | output | 1 | Registered data-in bit, frozen while paused |
| ser_dout | output | 1 | Data-out value for the pin driver |
| ser_oe | output | 1 | Enable for the data-out pin driver |
| paused | output | 1 | High while the pause is in effect |

## Verification
The bench drives the pause request in every order against the serial clock level. A design that pauses on a level instead of a clock-low qualification would pause while the clock is high. A design that resumes on any high level of the request would leave the pause at the later falling edge after a rise seen while the clock was high. The bench shifts a byte with a pause in the middle while clock pulses and data toggles arrive during the pause. A gate that leaks strobes would corrupt or lengthen the byte. It also drops the falling edge that starts a deferred pause, and it releases select while paused to check that the pause is cleared.

// File: rtl/serial_hold_gate.sv
module serial_hold_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_sel_n,
  input  logic ser_clk,
  input  logic ser_din,
  input  logic pause_req_n,
  input  logic core_dout,
  input  logic core_oe,
  output logic sel_active,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_bit,
  output logic ser_dout,
  output logic ser_oe,
  output logic paused
);
  localparam int PW = 4;
  localparam logic [PW-1:0] PIN_RST = 4'b1001;

  logic [PW-1:0] sync_q [SYNC_STAGES];
  logic sel_n_s, clk_s, din_s, req_n_s;
  logic clk_d, req_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= PIN_RST;
    end else begin
      sync_q[0] <= {bus_sel_n, ser_clk, ser_din, pause_req_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign {sel_n_s, clk_s, din_s, req_n_s} = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d   <= 1'b0;
      req_n_d <= 1'b1;
    end else begin
      clk_d   <= clk_s;
      req_n_d <= req_n_s;
    end
  end

  wire enter = !sel_n_s && !paused && !req_n_s && !clk_s;
  wire leave = paused && req_n_s && !req_n_d && !clk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       paused <= 1'b0;
    else if (sel_n_s) paused <= 1'b0;
    else if (enter)   paused <= 1'b1;
    else if (leave)   paused <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sdi_bit <= 1'b0;
    else if (!paused) sdi_bit <= din_s;
  end

  wire run = !sel_n_s && !paused;

  assign sel_active = !sel_n_s;
  assign sck_rise   = run && clk_s && !clk_d;
  assign sck_fall   = run && !clk_s && clk_d;
  assign ser_dout   = core_dout;
  assign ser_oe     = run && req_n_s && core_oe;
endmodule

// File: rtl/serial_hold_gate_props.sv
module serial_hold_gate_props (
  input logic clk,
  input logic rst_n,
  input logic sel_n_s,
  input logic clk_s,
  input logic req_n_s,
  input logic paused,
  input logic sck_rise,
  input logic sck_fall,
  input logic sdi_bit,
  input logic ser_oe
);
  AST_ENTER_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n_s && !paused && !req_n_s && !clk_s) |=> paused); // R1
  AST_ENTER_NOT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> !$past(clk_s)); // R2
  AST_STAY_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && clk_s && !sel_n_s) |=> paused); // R3
  AST_NO_STROBE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (!sck_rise && !sck_fall)); // R4
  AST_DIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && $past(paused)) |-> $stable(sdi_bit)); // R4
  AST_OE_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n_s || paused) |-> !ser_oe); // R5
  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> !paused); // R7
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise); // R8
endmodule

bind serial_hold_gate serial_hold_gate_props u_props (
  .clk(clk), .rst_n(rst_n), .sel_n_s(sel_n_s), .clk_s(clk_s),
  .req_n_s(req_n_s), .paused(paused), .sck_rise(sck_rise),
  .sck_fall(sck_fall), .sdi_bit(sdi_bit), .ser_oe(ser_oe)
);

// File: tb/tb_serial_hold_gate.sv
module tb_serial_hold_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0, pause_req_n = 1'b1;
  logic core_dout = 1'b0, core_oe = 1'b1;
  logic sel_active, sck_rise, sck_fall, sdi_bit, ser_dout, ser_oe, paused;

  int checks = 0, fails = 0;
  int rise_cnt = 0, fall_cnt = 0;
  logic [7:0] cap = '0;

  always #5 clk = ~clk;

  serial_hold_gate dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .pause_req_n(pause_req_n), .core_dout(core_dout),
    .core_oe(core_oe), .sel_active(sel_active), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .sdi_bit(sdi_bit), .ser_dout(ser_dout),
    .ser_oe(ser_oe), .paused(paused)
  );

  always @(negedge clk) begin
    if (sck_rise) begin
      rise_cnt <= rise_cnt + 1;
      cap <= {cap[6:0], sdi_bit};
    end
    if (sck_fall) fall_cnt <= fall_cnt + 1;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clk();
    ser_clk = 1'b1; wait_clks(4);
    ser_clk = 1'b0; wait_clks(4);
  endtask

  // {pause_req_n, ser_clk, expected paused, expected ser_oe}
  localparam int NV = 11;
  localparam logic [3:0] VEC [NV] = '{
    4'b1001, 4'b0010, 4'b0110, 4'b1110, 4'b1010, 4'b0010,
    4'b1001, 4'b1101, 4'b0100, 4'b0010, 4'b1001 };

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int f0;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(4);
    check("R5 reset oe", ser_oe, 0);
    check("R7 reset paused", paused, 0);
    check("R7 reset sel", sel_active, 0);

    bus_sel_n = 1'b0;
    wait_clks(4);
    for (int i = 0; i < NV; i++) begin
      f0 = fall_cnt;
      pause_req_n = VEC[i][3];
      ser_clk = VEC[i][2];
      wait_clks(4);
      check($sformatf("R1 R2 R3 paused vec %0d", i), paused, VEC[i][1]);
      check($sformatf("R5 oe vec %0d", i), ser_oe, VEC[i][0]);
      if (i == 9) check("R2 pausing fall forwarded", fall_cnt - f0, 1);
    end

    core_dout = 1'b1; wait_clks(1);
    check("R5 dout follows", ser_dout, 1);
    core_oe = 1'b0; wait_clks(1);
    check("R5 core_oe low", ser_oe, 0);
    core_oe = 1'b1;

    rise_cnt = 0;
    for (int b = 7; b >= 4; b--) begin
      ser_din = 8'hA6 >> b; wait_clks(2); pulse_clk();
    end
    pause_req_n = 1'b0; wait_clks(4);
    check("R1 mid byte paused", paused, 1);
    f0 = sdi_bit;
    for (int k = 0; k < 3; k++) begin
      ser_din = ~ser_din; pulse_clk();
    end
    check("R4 no rises paused", rise_cnt, 4);
    check("R4 sdi frozen", sdi_bit, f0);
    pause_req_n = 1'b1; wait_clks(4);
    check("R3 resumed", paused, 0);
    for (int b = 3; b >= 0; b--) begin
      ser_din = 8'hA6 >> b; wait_clks(2); pulse_clk();
    end
    check("R6 byte intact", cap, 8'hA6);
    check("R8 one rise per pulse", rise_cnt, 8);

    pause_req_n = 1'b0; wait_clks(4);
    check("R1 paused before deselect", paused, 1);
    bus_sel_n = 1'b1; wait_clks(4);
    check("R7 deselect clears", paused, 0);
    rise_cnt = 0;
    pause_req_n = 1'b1;
    pulse_clk();
    check("R7 no strobes deselected", rise_cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule